// File: doc/BRIEF.md
# Exception State Registers

This block keeps the exception state for a simple in-order processor: the address of the faulting instruction, the reason for the last exception, the processor mode and interrupt-enable history, the interrupt mask, and the last bad memory address. The pipeline gives it the current PC and reports a synchronous fault as a request with a 4-bit reason code and a faulting address. Five hardware interrupt lines come in from outside. The block decides in the same cycle whether an exception is taken, and it gives the fixed handler entry address that the PC must load.

Handler software reads and writes the registers through a small port indexed by register number. It returns from a handler with a strobe that restores the saved mode and enable bits. Interrupt requests are recorded as pending even while they are masked or globally disabled. The handler acknowledges a hardware level by writing a one to its pending bit.

Top module: `exc_state_regs`

## Requirements
- R1: After reset, every register reads zero: Status, Cause, the exception PC and the bad address. Zero in Status means kernel mode with interrupts disabled.
- R2: When an exception is taken, `take_exc_o` is 1 in that cycle and `handler_pc_o` is 0x80000080. On the next clock the exception PC holds `pc_i` minus 4.
- R3: Cause bits 5:2 hold the reason code of the last exception taken. A synchronous request stores `exc_code_i`, and an interrupt stores 0. Examples of codes: 4 and 5 address errors, 8 system call, 9 breakpoint, 10 reserved instruction, 12 overflow.
- R4: The bad-address register loads `fault_addr_i` only when a synchronous exception with code 4 or 5 is taken. Otherwise it keeps its value, and software writes do not change it.
- R5: Status bits 5:0 hold three pairs: old at 5:4, previous at 3:2 and current at 1:0. In each pair the high bit is 1 for user mode and the low bit is 1 for interrupts enabled. Taking an exception shifts bits 5:0 left by two, clears bits 1:0 and leaves the mask unchanged.
- R6: `rfe_i` shifts Status bits 5:0 right by two and the old pair keeps its value.
- R7: Cause bits 12:8 are the pending bits of hardware levels 0 to 4. A bit is set in any cycle its line is high, even while masked or disabled, and it stays set after the line drops. A software write to Cause with a 1 in that bit position clears it, unless the line is high in that cycle.
- R8: Cause bits 15:13 are software pending bits, loaded by software writes to Cause. Status bits 15:8 are the mask, one bit per Cause bit at the same position. An interrupt is taken when Status bit 0 is 1 and the pending bits ANDed with the mask are nonzero.
- R9: A synchronous request and an interrupt in the same cycle take a single exception, and it records the synchronous code.
- R10: Software register numbers: 8 bad address, 12 Status, 13 Cause, 14 exception PC. Any other number reads 0. A Status write keeps only bits 15:8 and 5:0. The exception PC is fully writable. Cause bits 5:2 are not writable.
- R11: In the same cycle, a taken exception overrides `rfe_i` and all software writes, and `rfe_i` overrides a Status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | 32 | PC of the instruction after the one being reported |
| exc_req_i | input | 1 | Synchronous exception request |
| exc_code_i | input | 4 | Reason code of the request |
| fault_addr_i | input | 32 | Faulting memory address |
| hw_irq_i | input | 5 | Hardware interrupt lines, levels 0 to 4 |
| rfe_i | input | 1 | Return-from-exception strobe |
| sw_we_i | input | 1 | Software write enable |
| sw_addr_i | input | 5 | Software register number |
| sw_wdata_i | input | 32 | Software write data |
| sw_rdata_o | output | 32 | Software read data, combinational |
| take_exc_o | output | 1 | Exception taken this cycle |
| handler_pc_o | output | 32 | Handler entry address |
| epc_o | output | 32 | Exception PC |
| cause_o | output | 32 | Cause register |
| status_o | output | 32 | Status register |
| badvaddr_o | output | 32 | Bad-address register |

## Verification
The hardest states to reach are the ones where events collide in one cycle: an interrupt that was latched while disabled and becomes live at the same moment a synchronous fault arrives, or a return strobe and a software write that land together with a taken exception. Directed steps build each collision on purpose. Some steps pend a level with interrupts off and then re-enable them by a Status write. Other steps raise a fault, the return strobe and a write all in one cycle. A long run of random stimulus with mixed strobes is then compared against a behavioural model on every clock.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned REG_AW = 5;
  localparam logic [REG_AW-1:0] REG_BADADDR = 5'd8;
  localparam logic [REG_AW-1:0] REG_STATUS  = 5'd12;
  localparam logic [REG_AW-1:0] REG_CAUSE   = 5'd13;
  localparam logic [REG_AW-1:0] REG_EPC     = 5'd14;
  localparam logic [XLEN-1:0]   HANDLER_PC  = 32'h8000_0080;
  localparam logic [3:0] CODE_INT      = 4'd0;
  localparam logic [3:0] CODE_ADDR_LD  = 4'd4;
  localparam logic [3:0] CODE_ADDR_ST  = 4'd5;
endpackage

// File: rtl/exc_status_stack.sv
module exc_status_stack #(
  parameter int unsigned PAIRS  = 3,
  parameter int unsigned MASK_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 push_i,
  input  logic                 pop_i,
  input  logic                 wr_i,
  input  logic [MASK_W-1:0]    wr_mask_i,
  input  logic [2*PAIRS-1:0]   wr_stack_i,
  output logic [MASK_W-1:0]    mask_o,
  output logic [2*PAIRS-1:0]   stack_o
);
  localparam int unsigned SW = 2 * PAIRS;

  logic [MASK_W-1:0] mask_q;
  logic [SW-1:0]     stack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      stack_q <= '0;
    end else if (push_i) begin
      stack_q <= {stack_q[SW-3:0], 2'b00};
    end else if (pop_i) begin
      stack_q <= {stack_q[SW-1 -: 2], stack_q[SW-1:2]};
    end else if (wr_i) begin
      mask_q  <= wr_mask_i;
      stack_q <= wr_stack_i;
    end
  end

  assign mask_o  = mask_q;
  assign stack_o = stack_q;

  AST_PUSH_KERNEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> stack_o[1:0] == 2'b00 && stack_o[SW-1:2] == $past(stack_o[SW-3:0])); // R5
  AST_PUSH_MASK_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> $stable(mask_o)); // R5
  AST_POP_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> stack_o[SW-3:0] == $past(stack_o[SW-1:2])
                           && stack_o[SW-1 -: 2] == $past(stack_o[SW-1 -: 2])); // R6
endmodule

// File: rtl/exc_pending.sv
module exc_pending #(
  parameter int unsigned NUM_HW = 5,
  parameter int unsigned NUM_SW = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_HW-1:0]          hw_irq_i,
  input  logic                       wr_i,
  input  logic [NUM_HW+NUM_SW-1:0]   wdata_i,
  output logic [NUM_HW+NUM_SW-1:0]   pend_o
);
  localparam int unsigned IRQ_W = NUM_HW + NUM_SW;

  logic [IRQ_W-1:0] pend_q;

  for (genvar i = 0; i < NUM_HW; i++) begin : g_hw
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    pend_q[i] <= 1'b0;
      else if (hw_irq_i[i])           pend_q[i] <= 1'b1;
      else if (wr_i && wdata_i[i])    pend_q[i] <= 1'b0; // write-one acknowledges
    end

    AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hw_irq_i[i] |=> pend_o[i]); // R7
    AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!hw_irq_i[i] && !wr_i) |=> pend_o[i] == $past(pend_o[i])); // R7
  end

  for (genvar j = NUM_HW; j < IRQ_W; j++) begin : g_sw
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   pend_q[j] <= 1'b0;
      else if (wr_i) pend_q[j] <= wdata_i[j];
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_pkg::*;
#(
  parameter int unsigned NUM_HW = 5,
  parameter int unsigned NUM_SW = 3,
  parameter int unsigned PAIRS  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              exc_req_i,
  input  logic [3:0]        exc_code_i,
  input  logic [XLEN-1:0]   fault_addr_i,
  input  logic [NUM_HW-1:0] hw_irq_i,
  input  logic              rfe_i,
  input  logic              sw_we_i,
  input  logic [REG_AW-1:0] sw_addr_i,
  input  logic [XLEN-1:0]   sw_wdata_i,
  output logic [XLEN-1:0]   sw_rdata_o,
  output logic              take_exc_o,
  output logic [XLEN-1:0]   handler_pc_o,
  output logic [XLEN-1:0]   epc_o,
  output logic [XLEN-1:0]   cause_o,
  output logic [XLEN-1:0]   status_o,
  output logic [XLEN-1:0]   badvaddr_o
);
  localparam int unsigned IRQ_W = NUM_HW + NUM_SW;
  localparam int unsigned SW    = 2 * PAIRS;
  localparam int unsigned IRQ_LO = 8;
  localparam int unsigned PAD_HI = XLEN - IRQ_LO - IRQ_W;
  localparam int unsigned PAD_ST = IRQ_LO - SW;

  logic [IRQ_W-1:0] mask, pend;
  logic [SW-1:0]    stack;
  logic             irq_hit, take, addr_err;
  logic [3:0]       code_q;
  logic [XLEN-1:0]  epc_q, bad_q;

  assign irq_hit  = stack[0] && |(pend & mask);
  assign take     = exc_req_i || irq_hit;
  assign addr_err = exc_req_i && (exc_code_i == CODE_ADDR_LD || exc_code_i == CODE_ADDR_ST);

  exc_status_stack #(.PAIRS(PAIRS), .MASK_W(IRQ_W)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (take),
    .pop_i      (rfe_i),
    .wr_i       (sw_we_i && sw_addr_i == REG_STATUS),
    .wr_mask_i  (sw_wdata_i[IRQ_LO +: IRQ_W]),
    .wr_stack_i (sw_wdata_i[SW-1:0]),
    .mask_o     (mask),
    .stack_o    (stack)
  );

  exc_pending #(.NUM_HW(NUM_HW), .NUM_SW(NUM_SW)) u_pend (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hw_irq_i (hw_irq_i),
    .wr_i     (sw_we_i && !take && sw_addr_i == REG_CAUSE),
    .wdata_i  (sw_wdata_i[IRQ_LO +: IRQ_W]),
    .pend_o   (pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      epc_q  <= '0;
      bad_q  <= '0;
    end else if (take) begin
      code_q <= exc_req_i ? exc_code_i : CODE_INT;
      epc_q  <= pc_i - XLEN'(4);
      if (addr_err) bad_q <= fault_addr_i;
    end else if (sw_we_i && sw_addr_i == REG_EPC) begin
      epc_q <= sw_wdata_i;
    end
  end

  assign status_o     = {{PAD_HI{1'b0}}, mask, {PAD_ST{1'b0}}, stack};
  assign cause_o      = {{PAD_HI{1'b0}}, pend, 2'b00, code_q, 2'b00};
  assign epc_o        = epc_q;
  assign badvaddr_o   = bad_q;
  assign take_exc_o   = take;
  assign handler_pc_o = HANDLER_PC;

  always_comb begin
    unique case (sw_addr_i)
      REG_BADADDR: sw_rdata_o = bad_q;
      REG_STATUS:  sw_rdata_o = status_o;
      REG_CAUSE:   sw_rdata_o = cause_o;
      REG_EPC:     sw_rdata_o = epc_q;
      default:     sw_rdata_o = '0;
    endcase
  end

  AST_EPC_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_exc_o |=> epc_o == $past(pc_i) - 32'd4); // R2
  AST_NO_IRQ_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exc_req_i && !status_o[0]) |-> !take_exc_o); // R8
  AST_SYNC_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_i |=> cause_o[5:2] == $past(exc_code_i)); // R9
  AST_BAD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_err |=> $stable(badvaddr_o)); // R4
  AST_EXC_OVER_EPC_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_exc_o && sw_we_i) |=> epc_o == $past(pc_i) - 32'd4); // R11
endmodule

// File: tb/exc_state_regs_tb_top.sv
module exc_state_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc, fa, wd;
  logic        exc, rfe, we;
  logic [3:0]  code;
  logic [4:0]  hw, addr;
  logic [31:0] rdata, hpc, epc, cause, status, bad;
  logic        take;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // behavioural reference state
  logic [31:0] m_st, m_epc, m_bad;
  logic [7:0]  m_pend;
  logic [3:0]  m_code;

  always #2 clk = ~clk;

  exc_state_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pc_i(pc), .exc_req_i(exc), .exc_code_i(code),
    .fault_addr_i(fa), .hw_irq_i(hw), .rfe_i(rfe), .sw_we_i(we), .sw_addr_i(addr),
    .sw_wdata_i(wd), .sw_rdata_o(rdata), .take_exc_o(take), .handler_pc_o(hpc),
    .epc_o(epc), .cause_o(cause), .status_o(status), .badvaddr_o(bad)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_cause();
    return {16'h0, m_pend, 2'b00, m_code, 2'b00};
  endfunction

  function automatic logic [31:0] m_read(logic [4:0] a);
    case (a)
      5'd8:    return m_bad;
      5'd12:   return m_st;
      5'd13:   return m_cause();
      5'd14:   return m_epc;
      default: return 32'h0;
    endcase
  endfunction

  task automatic step(string tag, bit e, logic [3:0] c, logic [31:0] p, logic [31:0] f,
                      logic [4:0] h, bit r, bit w, logic [4:0] a, logic [31:0] d);
    logic        m_take;
    logic [31:0] n_st, n_epc, n_bad;
    logic [7:0]  n_pend;
    logic [3:0]  n_code;
    exc = e; code = c; pc = p; fa = f; hw = h; rfe = r; we = w; addr = a; wd = d;
    #1;
    m_take = e || (m_st[0] && |(m_pend & m_st[15:8]));
    chk(tag, "take", {31'h0, take}, {31'h0, m_take});
    if (m_take) chk(tag, "handler", hpc, 32'h8000_0080);
    chk(tag, "rdata", rdata, m_read(a));
    n_st = m_st; n_epc = m_epc; n_bad = m_bad; n_pend = m_pend; n_code = m_code;
    if (m_take)            n_st[5:0] = {m_st[3:0], 2'b00};
    else if (r)            n_st[5:0] = {m_st[5:4], m_st[5:2]};
    else if (w && a == 12) n_st = {16'h0, d[15:8], 2'b00, d[5:0]};
    for (int i = 0; i < 5; i++) begin
      if (h[i]) n_pend[i] = 1'b1;
      else if (w && !m_take && a == 13 && d[8+i]) n_pend[i] = 1'b0;
    end
    if (w && !m_take && a == 13) n_pend[7:5] = d[15:13];
    if (m_take) begin
      n_code = e ? c : 4'd0;
      n_epc  = p - 32'd4;
      if (e && (c == 4 || c == 5)) n_bad = f;
    end else if (w && a == 14) n_epc = d;
    @(posedge clk);
    m_st = n_st; m_epc = n_epc; m_bad = n_bad; m_pend = n_pend; m_code = n_code;
    @(negedge clk);
    chk(tag, "status", status, m_st);
    chk(tag, "cause", cause, m_cause());
    chk(tag, "epc", epc, m_epc);
    chk(tag, "badvaddr", bad, m_bad);
  endtask

  task automatic idle(string tag, logic [4:0] a);
    step(tag, 0, 0, 32'h0, 32'h0, 5'h0, 0, 0, a, 32'h0);
  endtask

  task automatic swr(string tag, logic [4:0] a, logic [31:0] d);
    step(tag, 0, 0, 32'h0, 32'h0, 5'h0, 0, 1, a, d);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [3:0] codes [9];
    codes = '{4'd0, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10, 4'd12};
    exc = 0; code = 0; pc = 0; fa = 0; hw = 0; rfe = 0; we = 0; addr = 0; wd = 0;
    m_st = 0; m_epc = 0; m_bad = 0; m_pend = 0; m_code = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "status", status, 32'h0);
    chk("R1", "cause", cause, 32'h0);
    chk("R1", "epc", epc, 32'h0);
    chk("R1", "badvaddr", bad, 32'h0);
    chk("R1", "take", {31'h0, take}, 32'h0);
    @(negedge clk);

    // R10: Status write keeps 15:8 and 5:0 only
    swr("R10", 5'd12, 32'hFFFF_FFCD);
    idle("R10", 5'd12);
    // R2 R3 R5: reserved instruction exception
    step("R2", 1, 4'd10, 32'h0040_0010, 32'h0, 5'h0, 0, 0, 5'd14, 32'h0);
    idle("R5", 5'd13);
    // R6: return pops stack, old pair kept
    step("R6", 0, 0, 32'h0, 32'h0, 5'h0, 1, 0, 5'd12, 32'h0);
    // R4: address error captures, syscall leaves it
    step("R4", 1, 4'd4, 32'h0040_0020, 32'h1234_5679, 5'h0, 0, 0, 5'd8, 32'h0);
    step("R4", 1, 4'd8, 32'h0040_0030, 32'hAAAA_0000, 5'h0, 0, 0, 5'd8, 32'h0);
    step("R4", 1, 4'd5, 32'h0040_0040, 32'h0000_0BAD, 5'h0, 0, 0, 5'd8, 32'h0);
    swr("R4", 5'd8, 32'h5555_5555);
    idle("R4", 5'd8);
    // R7: pending latched while disabled
    swr("R7", 5'd12, 32'h0000_FF00);
    step("R7", 0, 0, 32'h0, 32'h0, 5'b00100, 0, 0, 5'd13, 32'h0);
    idle("R7", 5'd13);
    // R8: enabling fires interrupt, code 0
    swr("R8", 5'd12, 32'h0000_FF01);
    step("R8", 0, 0, 32'h0050_0004, 32'h0, 5'h0, 0, 0, 5'd13, 32'h0);
    // R7: acknowledge clears; line still high keeps it
    swr("R7", 5'd13, 32'h0000_0400);
    step("R7", 0, 0, 32'h0, 32'h0, 5'b00001, 0, 1, 5'd13, 32'h0000_0100);
    // R8: masked level does not fire
    swr("R8", 5'd12, 32'h0000_FE01);
    idle("R8", 5'd13);
    // R8: software pending fires through mask bit 15
    swr("R8", 5'd13, 32'h0000_8000);
    step("R8", 0, 0, 32'h0060_0008, 32'h0, 5'h0, 0, 0, 5'd13, 32'h0);
    // R9: sync and interrupt together
    swr("R9", 5'd12, 32'h0000_FF01);
    step("R9", 1, 4'd12, 32'h0070_0000, 32'h0, 5'h0, 0, 0, 5'd13, 32'h0);
    // R11: exception over return and writes
    swr("R11", 5'd13, 32'h0000_1F00);
    swr("R11", 5'd12, 32'h0000_0035);
    step("R11", 1, 4'd9, 32'h0080_0100, 32'h0, 5'h0, 1, 1, 5'd14, 32'h0000_DEAD);
    step("R11", 0, 0, 32'h0, 32'h0, 5'h0, 1, 1, 5'd12, 32'h0000_FF3F);
    // R10: unmapped read, EPC write
    swr("R10", 5'd14, 32'hCAFE_0004);
    idle("R10", 5'd3);

    for (int k = 0; k < 600; k++) begin
      bit          e, r, w;
      logic [4:0]  h, a;
      logic [4:0]  addrs [5];
      addrs = '{5'd8, 5'd12, 5'd13, 5'd14, 5'd3};
      e = ($urandom_range(0, 5) == 0);
      r = ($urandom_range(0, 7) == 0);
      w = ($urandom_range(0, 3) == 0);
      h = ($urandom_range(0, 5) == 0) ? 5'($urandom) : 5'h0;
      a = addrs[$urandom_range(0, 4)];
      step("R8", e, codes[$urandom_range(0, 8)], {$urandom, 2'b00} + 32'd4, $urandom,
           h, r, w, a, $urandom);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule